// File: doc/BRIEF.md
# Parallel Video and Message Capture Front End

This block samples a 10-bit parallel input bus on every rising edge of its capture clock. A data-valid strobe qualifies each sample. One of three formats is selected by configuration. In the 8-bit video format the low byte carries YUV 4:2:2 bytes. In the raw format all ten bits form one sample for a 10-bit converter. In the message format the low byte carries payload, bit 8 opens a message and bit 9 closes it.

Captured words leave on a valid/ready stream. Each word carries a 10-bit data field and first-word and last-word flags. A 16-entry FIFO buffers the stream. A word is transferred on a clock edge where `m_valid` and `m_ready` are both high. While `m_ready` is low, the head word and its flags are held unchanged. There is no back-pressure toward the input pins: a word that finds the FIFO full is discarded and the sticky `overflow` flag is set.

In message format the block holds each payload word for one step. This lets it tag the last payload word as last-of-message even when the closing marker arrives on its own, without a data-valid strobe. The path from the input pins to the output is registered at every stage.

Top module: `vcap_top`

## Requirements
- R1: A sample is taken only at a clock edge where both `vin_dv` and `cap_en` are high. Samples are never taken when either is low.
- R2: With `cfg_mode` = 0 (8-bit video; code 3 behaves the same), each sample gives one word with data = {2'b00, vin_data[7:0]} and both flags low.
- R3: With `cfg_mode` = 1 (raw), each sample gives one word with data = vin_data[9:0] and both flags low.
- R4: With `cfg_mode` = 2 (message), vin_data[8] is the open marker and vin_data[9] is the close marker. Both markers count only when `vin_dv` is high, unless bypass is on. Payload words carry data = {2'b00, vin_data[7:0]}. The first payload word after an open marker has `m_sop` set. The payload word sampled with the close marker, or else the last payload word before it, has `m_eop` set. A payload word sampled outside an open message is discarded. An open marker and a close marker in the same sample are handled as an open followed by a close.
- R5: With `cfg_bypass` = 1 in message mode, markers count at every enabled edge whatever `vin_dv` is, while payload bits stay gated by `vin_dv`.
- R6: An open marker while a message is already open sets the sticky `frame_err`. It ends the old message with `m_eop` on its last word and starts a new message.
- R7: A close marker with no open message sets `frame_err` and produces no word.
- R8: Words leave in arrival order. While `m_valid` is high and `m_ready` is low, `m_data`, `m_sop` and `m_eop` hold.
- R9: A word that finds all 16 FIFO entries occupied is discarded and `overflow` is set. `overflow` stays set until reset.
- R10: `cfg_mode` and `cfg_bypass` are loaded only at edges where `cap_en` is low. Changes while `cap_en` is high have no effect.
- R11: Synchronous active-high `rst` empties the FIFO, closes any message, clears `frame_err` and `overflow`, and selects 8-bit video with bypass off.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock; everything samples on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Capture enable; configuration loads while it is low |
| cfg_mode | input | 2 | Format: 0 video8, 1 raw, 2 message, 3 video8 |
| cfg_bypass | input | 1 | Markers ignore the data-valid strobe in message mode |
| vin_data | input | 10 | Parallel input bus |
| vin_dv | input | 1 | Data-valid strobe for `vin_data` |
| m_valid | output | 1 | A word is present on the output |
| m_ready | input | 1 | Sink accepts the word this edge |
| m_data | output | 10 | Word data field |
| m_sop | output | 1 | First word of a message |
| m_eop | output | 1 | Last word of a message |
| frame_err | output | 1 | Sticky marker-sequence error |
| overflow | output | 1 | Sticky dropped-word flag |

## Verification
The bench sweeps every format with strobe patterns made from a seeded random generator. In message mode it also sweeps markers in both bypass settings, and it checks each word against a queue built from the rules above. A design that tagged the end-of-message flag only on the closing sample would leave the last word of a message that is closed by a lone marker untagged. A design that gated markers by the strobe in bypass would lose whole messages. Directed cases cover a nested open, which must close the old message and raise the error flag, and a stray close, which must raise the flag and produce no word. They also cover a burst of 20 words into a stalled sink, where exactly the first 16 must survive. Other directed cases check that configuration changed during capture changes nothing, and that bits 9:8 are stripped in video format.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
  localparam int VCAP_DW = 10;
  localparam int VCAP_PW = 8;
  localparam int VCAP_OPEN_BIT = 8;
  localparam int VCAP_CLOSE_BIT = 9;

  typedef enum logic [1:0] {
    MODE_VID8  = 2'd0,
    MODE_RAW10 = 2'd1,
    MODE_MSG   = 2'd2,
    MODE_ALT8  = 2'd3
  } vcap_mode_e;

  typedef struct packed {
    logic               sop;
    logic               eop;
    logic [VCAP_DW-1:0] data;
  } vcap_word_t;

  localparam int VCAP_WW = $bits(vcap_word_t);
endpackage

// File: rtl/vcap_sampler.sv
module vcap_sampler
  import vcap_pkg::*;
#(
  parameter int DW = VCAP_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_bypass,
  input  logic [DW-1:0] vin_data,
  input  logic          vin_dv,
  output vcap_mode_e    mode_q,
  output logic          byp_q,
  output logic [DW-1:0] s_data,
  output logic          s_dv,
  output logic          s_cap
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_VID8;
      byp_q  <= 1'b0;
      s_data <= '0;
      s_dv   <= 1'b0;
      s_cap  <= 1'b0;
    end else begin
      if (!cap_en) begin
        mode_q <= vcap_mode_e'(cfg_mode);
        byp_q  <= cfg_bypass;
      end
      s_data <= vin_data;
      s_dv   <= vin_dv & cap_en;
      s_cap  <= cap_en;
    end
  end
endmodule

// File: rtl/vcap_framer.sv
module vcap_framer
  import vcap_pkg::*;
#(
  parameter int DW = VCAP_DW,
  parameter int PW = VCAP_PW
) (
  input  logic          clk,
  input  logic          rst,
  input  vcap_mode_e    mode,
  input  logic          byp,
  input  logic          s_cap,
  input  logic          s_dv,
  input  logic [DW-1:0] s_data,
  output logic          push,
  output vcap_word_t    push_word,
  output logic          ferr
);
  localparam int PAD = DW - PW;

  logic          open_q, hv_q, hsop_q, hfin_q, psop_q, ferr_q;
  logic [PW-1:0] hdata_q;
  logic          open_n, hv_n, hsop_n, hfin_n, psop_n, ferr_n;
  logic [PW-1:0] hdata_n;
  logic          push_n;
  vcap_word_t    word_n;
  logic          word_ok, mark_ok, mk_open, mk_close, in_msg;

  always_comb begin
    open_n  = open_q;
    hv_n    = hv_q;
    hsop_n  = hsop_q;
    hfin_n  = hfin_q;
    hdata_n = hdata_q;
    psop_n  = psop_q;
    ferr_n  = ferr_q;
    push_n  = 1'b0;
    word_n  = '0;
    word_ok  = s_cap & s_dv;
    mark_ok  = s_cap & (byp | s_dv);
    mk_open  = mark_ok & s_data[VCAP_OPEN_BIT];
    mk_close = mark_ok & s_data[VCAP_CLOSE_BIT];
    in_msg   = open_q | mk_open;
    unique case (mode)
      MODE_RAW10: begin
        push_n = word_ok;
        word_n.data = s_data;
        open_n = 1'b0;
        hv_n   = 1'b0;
      end
      MODE_MSG: begin
        // a finished word waiting in the hold slot leaves first
        if (hv_q && hfin_q) begin
          push_n = 1'b1;
          word_n = '{sop: hsop_q, eop: 1'b1, data: {{PAD{1'b0}}, hdata_q}};
          hv_n   = 1'b0;
          hfin_n = 1'b0;
        end
        if (mk_open) begin
          if (open_q) begin
            ferr_n = 1'b1;
            if (hv_q) begin
              push_n = 1'b1;
              word_n = '{sop: hsop_q, eop: 1'b1, data: {{PAD{1'b0}}, hdata_q}};
              hv_n   = 1'b0;
            end
          end
          open_n = 1'b1;
          psop_n = 1'b1;
        end
        if (mk_close && !in_msg) ferr_n = 1'b1;
        if (word_ok && in_msg) begin
          if (hv_n) begin
            push_n = 1'b1;
            word_n = '{sop: hsop_q, eop: 1'b0, data: {{PAD{1'b0}}, hdata_q}};
          end
          hv_n    = 1'b1;
          hdata_n = s_data[PW-1:0];
          hsop_n  = psop_n;
          psop_n  = 1'b0;
          hfin_n  = mk_close;
          if (mk_close) open_n = 1'b0;
        end else if (mk_close && in_msg) begin
          if (hv_n) begin
            push_n = 1'b1;
            word_n = '{sop: hsop_q, eop: 1'b1, data: {{PAD{1'b0}}, hdata_q}};
          end
          hv_n   = 1'b0;
          open_n = 1'b0;
        end
      end
      default: begin
        push_n = word_ok;
        word_n.data = {{PAD{1'b0}}, s_data[PW-1:0]};
        open_n = 1'b0;
        hv_n   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q    <= 1'b0;
      hv_q      <= 1'b0;
      hsop_q    <= 1'b0;
      hfin_q    <= 1'b0;
      hdata_q   <= '0;
      psop_q    <= 1'b0;
      ferr_q    <= 1'b0;
      push      <= 1'b0;
      push_word <= '0;
    end else begin
      open_q    <= open_n;
      hv_q      <= hv_n;
      hsop_q    <= hsop_n;
      hfin_q    <= hfin_n;
      hdata_q   <= hdata_n;
      psop_q    <= psop_n;
      ferr_q    <= ferr_n;
      push      <= push_n;
      push_word <= word_n;
    end
  end

  assign ferr = ferr_q;
endmodule

// File: rtl/vcap_fifo.sv
module vcap_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  output logic         full,
  output logic         ovf,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] rdata
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_wr, do_rd;

  assign full      = (count == CAP);
  assign out_valid = (count != '0);
  assign do_wr     = push & ~full;
  assign do_rd     = out_valid & out_ready;
  assign rdata     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(do_wr) - CW'(do_rd);
      if (push && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/vcap_top.sv
module vcap_top
  import vcap_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cap_en,
  input  logic [1:0]         cfg_mode,
  input  logic               cfg_bypass,
  input  logic [VCAP_DW-1:0] vin_data,
  input  logic               vin_dv,
  output logic               m_valid,
  input  logic               m_ready,
  output logic [VCAP_DW-1:0] m_data,
  output logic               m_sop,
  output logic               m_eop,
  output logic               frame_err,
  output logic               overflow
);
  vcap_mode_e         mode_q;
  logic               byp_q;
  logic [VCAP_DW-1:0] s_data;
  logic               s_dv, s_cap;
  logic               push, fifo_full;
  vcap_word_t         push_word, head;
  logic [VCAP_WW-1:0] head_bits;

  vcap_sampler #(.DW(VCAP_DW)) u_smp (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cfg_mode(cfg_mode),
    .cfg_bypass(cfg_bypass), .vin_data(vin_data), .vin_dv(vin_dv),
    .mode_q(mode_q), .byp_q(byp_q), .s_data(s_data), .s_dv(s_dv),
    .s_cap(s_cap)
  );

  vcap_framer #(.DW(VCAP_DW), .PW(VCAP_PW)) u_frm (
    .clk(clk), .rst(rst), .mode(mode_q), .byp(byp_q), .s_cap(s_cap),
    .s_dv(s_dv), .s_data(s_data), .push(push), .push_word(push_word),
    .ferr(frame_err)
  );

  vcap_fifo #(.W(VCAP_WW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .wdata(push_word), .full(fifo_full),
    .ovf(overflow), .out_valid(m_valid), .out_ready(m_ready),
    .rdata(head_bits)
  );

  assign head   = vcap_word_t'(head_bits);
  assign m_data = head.data;
  assign m_sop  = head.sop;
  assign m_eop  = head.eop;
endmodule

// File: rtl/vcap_checker.sv
module vcap_checker
  import vcap_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               cap_en,
  input logic               m_valid,
  input logic               m_ready,
  input logic [VCAP_DW-1:0] m_data,
  input logic               m_sop,
  input logic               m_eop,
  input logic               frame_err,
  input logic               overflow,
  input vcap_mode_e         mode_q,
  input logic               byp_q,
  input logic               push,
  input logic               fifo_full
);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_sop) && $stable(m_eop)));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    (push && fifo_full) |=> overflow);

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  p_ferr_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> frame_err);

  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> ($stable(mode_q) && $stable(byp_q)));

  p_flag_payload_r4: assert property (@(posedge clk) disable iff (rst)
    (m_valid && (m_sop || m_eop)) |-> (m_data[VCAP_DW-1:VCAP_PW] == '0));
endmodule

bind vcap_top vcap_checker u_chk (
  .clk(clk), .rst(rst), .cap_en(cap_en), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data), .m_sop(m_sop), .m_eop(m_eop), .frame_err(frame_err),
  .overflow(overflow), .mode_q(mode_q), .byp_q(byp_q), .push(push),
  .fifo_full(fifo_full)
);

// File: tb/tb_vcap_top.sv
module tb_vcap_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cap_en = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic       cfg_bypass = 1'b0;
  logic [9:0] vin_data = '0;
  logic       vin_dv = 1'b0;
  logic       m_ready = 1'b1;
  logic       m_valid, m_sop, m_eop, frame_err, overflow;
  logic [9:0] m_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  string cur_req = "R2";

  logic [11:0] exp_q[$];
  bit         md_open, md_pv, md_psop, md_ferr;
  logic [9:0] md_pend;
  bit         md_pend_sop;

  always #5 clk = ~clk;

  vcap_top dut (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cfg_mode(cfg_mode),
    .cfg_bypass(cfg_bypass), .vin_data(vin_data), .vin_dv(vin_dv),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_sop(m_sop),
    .m_eop(m_eop), .frame_err(frame_err), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input logic [11:0] act,
                     input logic [11:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && m_valid && m_ready) begin
      if (exp_q.size() == 0)
        chk(1'b0, "R8", {m_sop, m_eop, m_data}, 12'h000);
      else begin
        logic [11:0] e;
        e = exp_q.pop_front();
        chk({m_sop, m_eop, m_data} == e, cur_req, {m_sop, m_eop, m_data}, e);
      end
    end
  end

  // requirement-level model: expected words as {sop, eop, data}
  task automatic model(input int mode, input bit byp, input bit dv, input logic [9:0] d);
    bit st, en, was_open, in_msg, mk;
    if (mode == 1) begin
      if (dv) exp_q.push_back({2'b00, d});
      return;
    end
    if (mode != 2) begin
      if (dv) exp_q.push_back({2'b00, 2'b00, d[7:0]});
      return;
    end
    mk = byp || dv;
    st = mk && d[8];
    en = mk && d[9];
    was_open = md_open;
    in_msg = was_open || st;
    if (st) begin
      if (was_open) begin
        md_ferr = 1'b1;
        if (md_pv) exp_q.push_back({md_pend_sop, 1'b1, md_pend});
        md_pv = 1'b0;
      end
      md_open = 1'b1;
      md_psop = 1'b1;
    end
    if (en && !in_msg) md_ferr = 1'b1;
    if (dv && in_msg) begin
      if (md_pv) exp_q.push_back({md_pend_sop, 1'b0, md_pend});
      if (en) begin
        exp_q.push_back({md_psop, 1'b1, 2'b00, d[7:0]});
        md_pv = 1'b0;
        md_open = 1'b0;
      end else begin
        md_pv = 1'b1;
        md_pend = {2'b00, d[7:0]};
        md_pend_sop = md_psop;
      end
      md_psop = 1'b0;
    end else if (en && in_msg) begin
      if (md_pv) exp_q.push_back({md_pend_sop, 1'b1, md_pend});
      md_pv = 1'b0;
      md_open = 1'b0;
    end
  endtask

  task automatic cyc(input int mode, input bit byp, input bit cap, input bit dv,
                     input logic [9:0] d, input bit rdy);
    @(posedge clk);
    #1;
    cap_en = cap; vin_dv = dv; vin_data = d; m_ready = rdy;
    if (cap) model(mode, byp, dv, d);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1; cap_en = 1'b0; vin_dv = 1'b0; vin_data = '0; m_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    exp_q.delete();
    md_open = 0; md_pv = 0; md_psop = 0; md_ferr = 0; md_pend = '0; md_pend_sop = 0;
  endtask

  task automatic start_phase(input int mode, input bit byp, input string req);
    do_reset();
    cur_req = req;
    cfg_mode = 2'(mode);
    cfg_bypass = byp;
    repeat (2) @(posedge clk);
  endtask

  task automatic end_phase(input int mode, input bit byp, input string req);
    for (int i = 0; i < 40; i++) cyc(mode, byp, 1'b1, 1'b0, 10'h000, 1'b1);
    @(negedge clk);
    chk(exp_q.size() == 0, req, 12'(exp_q.size()), 12'h000);
    chk(frame_err == md_ferr, req, {11'h0, frame_err}, {11'h0, md_ferr});
    chk(overflow == 1'b0, "R9", {11'h0, overflow}, 12'h000);
  endtask

  task automatic run_rand(input int mode, input bit byp, input int n, input bit gate_cap);
    for (int i = 0; i < n; i++) begin
      logic [9:0] d;
      bit cap, dv;
      cap = gate_cap ? (($urandom % 8) != 0) : 1'b1;
      dv  = (i % 3 != 0) && ($urandom % 2 == 1);
      d   = 10'($urandom);
      if (mode == 2) begin
        d[8] = ($urandom % 6) == 0;
        d[9] = ($urandom % 6) == 0;
      end
      cyc(mode, byp, cap, dv, d, (i % 4) != 3);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R11: reset state
    do_reset();
    @(negedge clk);
    chk(m_valid == 0 && frame_err == 0 && overflow == 0, "R11",
        {9'h0, m_valid, frame_err, overflow}, 12'h000);

    // R2 with R10: mode changed to raw while capture runs must not apply
    start_phase(0, 0, "R2");
    cap_en = 1'b1;
    @(posedge clk); #1 cfg_mode = 2'd1;
    cur_req = "R10";
    for (int i = 0; i < 60; i++) cyc(0, 0, 1'b1, 1'b1, 10'h300 | 10'(i), 1'b1);
    cfg_mode = 2'd0;
    cur_req = "R2";
    run_rand(0, 0, 400, 1'b0);
    end_phase(0, 0, "R2");

    // R3 with R1: raw format, capture enable toggled
    start_phase(1, 0, "R3");
    cur_req = "R1";
    run_rand(1, 0, 500, 1'b1);
    end_phase(1, 0, "R3");

    // R4: message framing, markers gated by strobe
    start_phase(2, 0, "R4");
    cyc(2, 0, 1, 0, 10'h100, 1);   // open without strobe: ignored
    cyc(2, 0, 1, 1, 10'h077, 1);   // outside message: dropped
    cyc(2, 0, 1, 1, 10'h1A1, 1);   // open + word
    cyc(2, 0, 1, 1, 10'h0B2, 1);
    cyc(2, 0, 1, 0, 10'h200, 1);   // close without strobe: ignored
    cyc(2, 0, 1, 1, 10'h3C3, 1);   // open+close: restart then single word
    cyc(2, 0, 1, 1, 10'h0D4, 1);   // dropped
    run_rand(2, 0, 700, 1'b0);
    end_phase(2, 0, "R4");

    // R5: bypass, markers honoured without strobe
    start_phase(2, 1, "R5");
    cyc(2, 1, 1, 0, 10'h100, 1);
    cyc(2, 1, 1, 0, 10'h0EE, 1);   // payload without strobe: ignored
    cyc(2, 1, 1, 1, 10'h0AB, 1);
    cyc(2, 1, 1, 1, 10'h0CD, 1);
    cyc(2, 1, 1, 0, 10'h200, 1);   // lone close tags CD as last
    repeat (8) cyc(2, 1, 1, 0, 10'h000, 1);
    @(negedge clk);
    chk(exp_q.size() == 0, "R5", 12'(exp_q.size()), 12'h000);
    run_rand(2, 1, 700, 1'b0);
    end_phase(2, 1, "R5");

    // R6: nested open
    start_phase(2, 0, "R6");
    cyc(2, 0, 1, 1, 10'h155, 1);
    cyc(2, 0, 1, 1, 10'h011, 1);
    cyc(2, 0, 1, 1, 10'h022, 1);
    cyc(2, 0, 1, 1, 10'h133, 1);
    cyc(2, 0, 1, 1, 10'h244, 1);
    end_phase(2, 0, "R6");
    chk(frame_err == 1'b1, "R6", {11'h0, frame_err}, 12'h001);

    // R7: stray close
    start_phase(2, 0, "R7");
    cyc(2, 0, 1, 1, 10'h2AA, 1);
    end_phase(2, 0, "R7");
    chk(frame_err == 1'b1 && m_valid == 1'b0, "R7", {10'h0, frame_err, m_valid}, 12'h002);

    // R9 and R8: burst into stalled sink
    start_phase(1, 0, "R9");
    cap_en = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      m_ready = 1'b0; vin_dv = 1'b1; vin_data = 10'(i + 10'h200);
    end
    @(posedge clk); #1 vin_dv = 1'b0;
    for (int i = 0; i < 16; i++) exp_q.push_back({2'b00, 10'(i + 10'h200)});
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(overflow == 1'b1, "R9", {11'h0, overflow}, 12'h001);
    chk(m_valid && m_data == 10'h200, "R8", {1'b0, m_valid, m_data}, 12'h600);
    @(negedge clk);
    chk(m_data == 10'h200, "R8", {2'b0, m_data}, 12'h200);
    cur_req = "R8";
    @(posedge clk); #1 m_ready = 1'b1;
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R8", 12'(exp_q.size()), 12'h000);
    chk(overflow == 1'b1, "R9", {11'h0, overflow}, 12'h001);

    // R11: reset clears sticky flags
    do_reset();
    @(negedge clk);
    chk(overflow == 0 && m_valid == 0, "R11", {10'h0, overflow, m_valid}, 12'h000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule